// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

A register-mapped serial port that moves 8N1 bytes between a processor bus and a pair of serial pins. Software programs an 8-bit bit-rate divisor and enables the transmitter and receiver. It then pushes bytes into a 16-entry transmit queue and pops received bytes from a 16-entry receive queue. A single count register reports how full each queue is.

Received frames are checked for a bad stop bit and for a line held low for a whole frame. A byte that arrives while the receive queue is full is flagged as an overrun and discarded. Status flags are cleared by the usual handshake: software reads the flag as 1, then writes 0 to that bit. A level interrupt output is high while any receive-side flag is set.

Register map (byte offsets): 0x00 mode (storage only), 0x04 divisor, 0x08 control, 0x0C transmit byte, 0x10 status, 0x14 receive byte, 0x18 queue control, 0x1C queue counts, 0x24 line status.

Top module: `fifo_serial_port`

## Requirements
- R1: After reset the tx pin is high, status (0x10) reads 0x0040, the count register (0x1C) reads 0, line status (0x24) reads 0 and irq is low.
- R2: One bit lasts 32·(N+1) clocks, where N is the divisor at 0x04. A frame is a low start bit, eight data bits sent LSB first, and a high stop bit. When the transmitter is idle and enabled, the start bit appears one cycle after the clock edge that queues the byte. Back-to-back frames are separated by one idle high cycle.
- R3: While control bit 5 is 0, no frame starts, the tx pin stays high and written bytes stay queued.
- R4: The transmit queue holds 16 bytes, and its fill level appears in count bits 12:8. A write to 0x0C while the queue is full is ignored.
- R5: Status bit 6 (transmit finished) is cleared by any accepted write to 0x0C. It is set at the end of the last stop bit when the transmit queue is empty.
- R6: The receiver detects a start bit, samples each bit at mid-period and stores the byte. The receive fill level appears in count bits 4:0, and reads of 0x14 return bytes in arrival order and pop them.
- R7: Reading 0x14 while the receive queue is empty returns the last byte popped and leaves the count unchanged.
- R8: A stored byte sets status bit 0 if the receive count after storing is below 4, and status bit 1 otherwise. irq is high while any of status bits 0, 1, 3, 4, 7 or line-status bit 0 is set.
- R9: A frame with a 0 stop bit and non-zero data sets status bits 3 and 7, and its byte is still stored.
- R10: A frame that is all zeros, stop bit included, sets status bits 4, 3 and 7 and stores nothing.
- R11: A good frame that completes while 16 bytes are queued sets line-status bit 0, and that byte is dropped.
- R12: A flag clears only when 0 is written to its bit and it was read as 1 since the previous write to that register. Writing 1 keeps a flag, so writing 0x00FC after a read clears bits 0 and 1 only.
- R13: Queue control bit 1 empties the receive queue and bit 2 empties the transmit queue. Each queue is held empty and refuses new bytes while its bit is 1.
- R14: While control bit 4 is 0, incoming frames are neither stored nor flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops and arms flags) |
| addr | input | 6 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| rx_in | input | 1 | Serial receive pin |
| tx_out | output | 1 | Serial transmit pin |
| irq | output | 1 | Level interrupt for receive-side flags |

## Verification
Register writes take effect at the next clock edge, and register reads are combinational in the same cycle. The bench therefore samples rdata shortly after the falling edge of the cycle in which it asserts rd_en. The tx pin is checked on every falling edge against a behavioural queue model that starts a frame on the edge after a byte is queued and advances one bit every 32·(N+1) edges. Receive results become visible a few ticks after the middle of the stop bit. Status, count and irq checks therefore wait until the stop bit and one further idle bit have been driven, so they never depend on the exact sample tick.

// File: rtl/fifo_serial_port.sv
module fifo_serial_port #(
  parameter int DEPTH   = 16,
  parameter int RX_TRIG = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        rx_in,
  output logic        tx_out,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [5:0] A_MODE = 6'h00, A_DIV = 6'h04, A_CTRL = 6'h08, A_TXD = 6'h0C,
                         A_STAT = 6'h10, A_RXD = 6'h14, A_FCR = 6'h18, A_CNT = 6'h1C,
                         A_LINE = 6'h24;
  typedef enum logic [1:0] {R_IDLE, R_ACT, R_WAIT} rx_state_t;

  logic [15:0] mode_q, ctrl_q, fcr_q;
  logic [7:0]  div_q;
  logic tx_en, rx_en, tx_clr, rx_clr;
  assign tx_en  = ctrl_q[5];
  assign rx_en  = ctrl_q[4];
  assign tx_clr = fcr_q[2];
  assign rx_clr = fcr_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; ctrl_q <= '0; fcr_q <= '0; div_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE: mode_q <= wdata;
        A_DIV:  div_q  <= wdata[7:0];
        A_CTRL: ctrl_q <= wdata;
        A_FCR:  fcr_q  <= wdata;
        default: ;
      endcase
    end
  end

  // transmit queue and shifter
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy, tx_push, tx_pop, tx_bit_end, tx_frame_end;
  logic [9:0]    tx_sh;
  logic [12:0]   tx_tclk;
  logic [3:0]    tx_bit;

  assign tx_push      = wr_en && addr == A_TXD && tx_cnt != CW'(DEPTH) && !tx_clr;
  assign tx_pop       = !tx_busy && tx_en && tx_cnt != '0 && !tx_clr;
  assign tx_bit_end   = tx_busy && tx_tclk == {div_q, 5'h1f};
  assign tx_frame_end = tx_bit_end && tx_bit == 4'd9;
  assign tx_out       = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_tclk <= '0; tx_bit <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1; tx_sh <= {1'b1, tx_mem[tx_rp], 1'b0}; tx_tclk <= '0; tx_bit <= '0;
    end else if (tx_busy) begin
      if (tx_bit_end) begin
        tx_tclk <= '0;
        tx_sh   <= {1'b1, tx_sh[9:1]};
        tx_bit  <= tx_bit + 1'b1;
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
      end else tx_tclk <= tx_tclk + 1'b1;
    end
  end

  // receive oversampling (16 ticks per bit, tick every 2*(N+1) clocks)
  logic [8:0] pre;
  logic       tick;
  assign tick = pre == {div_q, 1'b1};
  always_ff @(posedge clk) pre <= (!rst_n || tick) ? '0 : pre + 1'b1;

  logic       rx_s1, rx_s2;
  rx_state_t  rx_st;
  logic [3:0] rx_sub, rx_bit;
  logic [7:0] rx_sh;
  always_ff @(posedge clk) begin
    if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
    else begin rx_s1 <= rx_in; rx_s2 <= rx_s1; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      rx_st <= R_IDLE; rx_sub <= '0; rx_bit <= '0; rx_sh <= '0;
    end else begin
      case (rx_st)
        R_IDLE: if (tick && !rx_s2) begin rx_st <= R_ACT; rx_sub <= '0; rx_bit <= '0; end
        R_ACT: if (tick) begin
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == 4'd7) begin
            if (rx_bit == 4'd0) begin
              if (rx_s2) rx_st <= R_IDLE;
              else       rx_bit <= 4'd1;
            end else if (rx_bit == 4'd9) begin
              rx_st <= rx_s2 ? R_IDLE : R_WAIT;
            end else begin
              rx_sh  <= {rx_s2, rx_sh[7:1]};
              rx_bit <= rx_bit + 1'b1;
            end
          end
        end
        default: if (rx_s2) rx_st <= R_IDLE;
      endcase
    end
  end

  logic rx_done, rx_fe, rx_brk, rx_keep, rx_push, rx_ovr, rx_pop, rx_hi;
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_last;
  assign rx_done = rx_st == R_ACT && tick && rx_sub == 4'd7 && rx_bit == 4'd9;
  assign rx_fe   = rx_done && !rx_s2;
  assign rx_brk  = rx_fe && rx_sh == 8'h00;
  assign rx_keep = rx_done && !rx_brk && !rx_clr;
  assign rx_push = rx_keep && rx_cnt != CW'(DEPTH);
  assign rx_ovr  = rx_keep && rx_cnt == CW'(DEPTH);
  assign rx_pop  = rd_en && addr == A_RXD && rx_cnt != '0 && !rx_clr;
  assign rx_hi   = rx_cnt >= CW'(RX_TRIG - 1);

  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_last <= '0;
    else if (rx_pop) rx_last <= rx_mem[rx_rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      if (rx_push && !rx_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  // flags: cleared by writing 0 after reading 1
  logic [7:0] st_q, st_arm, st_set, st_clr;
  logic       ln_q, ln_arm, wr_st, rd_st, wr_ln, rd_ln;
  assign wr_st  = wr_en && addr == A_STAT;
  assign rd_st  = rd_en && addr == A_STAT;
  assign wr_ln  = wr_en && addr == A_LINE;
  assign rd_ln  = rd_en && addr == A_LINE;
  assign st_set = {rx_fe, tx_frame_end && tx_cnt == '0 && !tx_push, 1'b0, rx_brk, rx_fe,
                   1'b0, rx_push && rx_hi, rx_push && !rx_hi};
  assign st_clr = (wr_st ? (st_arm & ~wdata[7:0]) : 8'h00) | {1'b0, tx_push, 6'h00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 8'h40; st_arm <= '0; ln_q <= 1'b0; ln_arm <= 1'b0;
    end else begin
      st_q   <= (st_q & ~st_clr) | st_set;
      st_arm <= wr_st ? 8'h00 : (rd_st ? (st_arm | st_q) : st_arm);
      ln_q   <= (ln_q & ~(wr_ln && ln_arm && !wdata[0])) | rx_ovr;
      ln_arm <= wr_ln ? 1'b0 : (rd_ln ? (ln_arm | ln_q) : ln_arm);
    end
  end

  assign irq = |{st_q[7], st_q[4], st_q[3], st_q[1], st_q[0], ln_q};

  always_comb begin
    case (addr)
      A_MODE: rdata = mode_q;
      A_DIV:  rdata = {8'h00, div_q};
      A_CTRL: rdata = ctrl_q;
      A_STAT: rdata = {8'h00, st_q};
      A_RXD:  rdata = {8'h00, (rx_cnt != '0) ? rx_mem[rx_rp] : rx_last};
      A_FCR:  rdata = fcr_q;
      A_CNT:  rdata = {3'b000, 5'(tx_cnt), 3'b000, 5'(rx_cnt)};
      A_LINE: rdata = {15'h0000, ln_q};
      default: rdata = 16'h0000;
    endcase
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |=> !tx_out);
  // R4
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH));
  // R5
  tend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_push |=> !st_q[6]);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXD && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);
  // R11
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ln_q) |-> $past(rx_cnt) == CW'(DEPTH));
  // R13
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> rx_cnt == '0);
endmodule

// File: tb/fifo_serial_port_test.sv
module fifo_serial_port_test;
  localparam int CLK_P = 10;
  localparam int DIV   = 1;
  localparam int BIT   = 32 * (DIV + 1);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rx_in = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tx_out, irq;
  int checks = 0, fails = 0;

  fifo_serial_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata), .rx_in(rx_in), .tx_out(tx_out), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  // behavioural transmit model
  logic [7:0] mq[$];
  int mbusy = 0, mtim = 0, mbit = 0, p;
  logic [9:0] mfrm = '1;
  logic mtxen = 0, mtclr = 0, exp_tx = 1'b1, acc;
  logic [7:0] mdiv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mbusy = 0; mtxen = 0; mtclr = 0; mdiv = 0;
    end else begin
      p = 32 * (mdiv + 1);
      acc = wr_en && addr == 6'h0C && mq.size() < 16 && !mtclr;
      if (mbusy != 0) begin
        if (mtim == p - 1) begin
          mtim = 0;
          if (mbit == 9) mbusy = 0; else mbit++;
        end else mtim++;
      end else if (mtxen && mq.size() > 0 && !mtclr) begin
        mfrm = {1'b1, mq.pop_front(), 1'b0}; mbusy = 1; mtim = 0; mbit = 0;
      end
      if (mtclr) mq.delete();
      if (acc) mq.push_back(wdata[7:0]);
      if (wr_en && addr == 6'h08) mtxen = wdata[5];
      if (wr_en && addr == 6'h18) mtclr = wdata[2];
      if (wr_en && addr == 6'h04) mdiv = wdata[7:0];
    end
    exp_tx = (mbusy != 0) ? mfrm[mbit] : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (tx_out !== exp_tx) begin
        fails++;
        $display("FAIL R2/R3 tx_out at %0t actual=%b expected=%b", $time, tx_out, exp_tx);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [5:0] a, int exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  function automatic int cnt_val(int ntx, int nrx);
    return (ntx << 8) | nrx;
  endfunction

  task automatic send(logic [7:0] b, logic stop);
    @(negedge clk); rx_in = 1'b0;
    repeat (BIT - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; repeat (BIT) @(negedge clk); end
    rx_in = stop; repeat (BIT) @(negedge clk);
    rx_in = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [15:0] d;
    rd(6'h10, d); wr(6'h10, 16'h0000);
    rd(6'h24, d); wr(6'h24, 16'h0000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 tx_out", int'(tx_out), 1);
    chk("R1 irq", int'(irq), 0);
    chk_reg("R1 status", 6'h10, 16'h0040);
    chk_reg("R1 count", 6'h1C, 0);
    chk_reg("R1 line", 6'h24, 0);

    wr(6'h04, DIV);
    // R3: transmitter disabled keeps bytes queued
    wr(6'h08, 16'h0010);
    wr(6'h0C, 16'h00A5); wr(6'h0C, 16'h003C);
    repeat (200) @(negedge clk);
    chk_reg("R3 queued", 6'h1C, cnt_val(2, 0));
    // R2/R5: enable and send
    wr(6'h08, 16'h0030);
    repeat (100) @(negedge clk);
    chk_reg("R5 busy", 6'h10, 16'h0000);
    repeat (1500) @(negedge clk);
    chk_reg("R2 drained", 6'h1C, 0);
    chk_reg("R5 end", 6'h10, 16'h0040);
    wr(6'h0C, 16'h0081);
    chk_reg("R5 write clears", 6'h10, 16'h0000);
    repeat (800) @(negedge clk);
    chk_reg("R5 end again", 6'h10, 16'h0040);

    // R4: capacity
    wr(6'h08, 16'h0010);
    for (int i = 0; i < 17; i++) wr(6'h0C, 16'(i + 1));
    chk_reg("R4 full", 6'h1C, cnt_val(16, 0));
    // R13: transmit queue reset
    wr(6'h18, 16'h0004);
    repeat (3) @(negedge clk);
    chk_reg("R13 tx flush", 6'h1C, 0);
    wr(6'h0C, 16'h0055);
    chk_reg("R13 tx held", 6'h1C, 0);
    wr(6'h18, 16'h0000);
    wr(6'h0C, 16'h0066);
    chk_reg("R13 tx resume", 6'h1C, cnt_val(1, 0));
    wr(6'h08, 16'h0030);
    repeat (800) @(negedge clk);
    chk_reg("R2 sent", 6'h1C, 0);
    clear_all();
    chk_reg("R12 cleared", 6'h10, 16'h0000);

    // R6/R8: reception
    send(8'h5A, 1'b1);
    chk_reg("R6 one", 6'h1C, cnt_val(0, 1));
    chk_reg("R8 ready", 6'h10, 16'h0001);
    chk("R8 irq", int'(irq), 1);
    send(8'h12, 1'b1); send(8'h34, 1'b1); send(8'h56, 1'b1);
    chk_reg("R6 four", 6'h1C, cnt_val(0, 4));
    chk_reg("R8 threshold", 6'h10, 16'h0003);
    chk_reg("R6 b0", 6'h14, 16'h005A);
    chk_reg("R6 b1", 6'h14, 16'h0012);
    chk_reg("R6 b2", 6'h14, 16'h0034);
    chk_reg("R6 b3", 6'h14, 16'h0056);
    chk_reg("R6 empty", 6'h1C, 0);
    chk_reg("R7 last", 6'h14, 16'h0056);
    chk_reg("R7 count", 6'h1C, 0);

    // R12: clearing handshake
    wr(6'h10, 16'h00FC);
    chk_reg("R12 FC", 6'h10, 16'h0000);
    chk("R12 irq", int'(irq), 0);
    send(8'h77, 1'b1);
    wr(6'h10, 16'h0000);
    chk_reg("R12 unread kept", 6'h10, 16'h0001);
    wr(6'h10, 16'h00FF);
    chk_reg("R12 one kept", 6'h10, 16'h0001);
    wr(6'h10, 16'h0000);
    chk_reg("R12 zero clears", 6'h10, 16'h0000);
    chk_reg("R6 b4", 6'h14, 16'h0077);

    // R9: framing error
    send(8'h33, 1'b0);
    chk_reg("R9 flags", 6'h10, 16'h0089);
    chk("R9 irq", int'(irq), 1);
    chk_reg("R9 stored", 6'h14, 16'h0033);
    clear_all();

    // R10: break
    send(8'h00, 1'b0);
    chk_reg("R10 flags", 6'h10, 16'h0098);
    chk_reg("R10 nothing stored", 6'h1C, 0);
    clear_all();
    chk_reg("R10 cleared", 6'h10, 16'h0000);

    // R11: overrun
    for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 1'b1);
    chk_reg("R11 line", 6'h24, 1);
    chk_reg("R11 count", 6'h1C, cnt_val(0, 16));
    chk_reg("R8 flags", 6'h10, 16'h0003);
    for (int i = 0; i < 16; i++) chk_reg("R11 order", 6'h14, 16'h0040 + i);
    chk_reg("R11 dropped", 6'h1C, 0);
    clear_all();
    chk_reg("R11 cleared", 6'h24, 0);
    chk("R8 irq low", int'(irq), 0);

    // R13: receive queue reset
    send(8'h99, 1'b1);
    chk_reg("R13 rx one", 6'h1C, cnt_val(0, 1));
    wr(6'h18, 16'h0002);
    repeat (2) @(negedge clk);
    chk_reg("R13 rx flush", 6'h1C, 0);
    send(8'h98, 1'b1);
    chk_reg("R13 rx held", 6'h1C, 0);
    wr(6'h18, 16'h0000);
    send(8'h97, 1'b1);
    chk_reg("R13 rx resume", 6'h1C, cnt_val(0, 1));
    chk_reg("R13 rx data", 6'h14, 16'h0097);
    clear_all();

    // R14: receiver disabled
    wr(6'h08, 16'h0020);
    send(8'hAB, 1'b1);
    chk_reg("R14 count", 6'h1C, 0);
    chk_reg("R14 status", 6'h10, 16'h0000);
    chk("R14 irq", int'(irq), 0);

    finish_run();
  end
endmodule